// File: doc/BRIEF.md
# Line Clamp and Blank Pulse Generator

This block generates three horizontal-rate control pulses for an image-sensor readout line: an active-low optical-black clamp pulse, an active-low pre-blank pulse and an active-high horizontal blanking pulse. A pixel counter runs on the pixel clock and restarts on every line-start strobe. Each pulse is built from a start level and a list of toggle positions counted in pixels from line start. While blanking is active, the block also forces the four horizontal clock lines to a fixed pattern.

Settings come from a bank of register sets. There is one set per vertical sequence, and the set in force is chosen by a sequence index that is captured at each line start. The blanking pulse has six toggle positions. A two-bit alternation field can split them between odd and even lines: the first two toggles on one parity and the last four on the other. The line parity is also captured at line start.

A three-state line machine drives the counter. WAIT is the state after reset, before any line start has arrived; the outputs stay idle. RUN is the state in which the counter advances one pixel per clock. END is the state in which the counter has saturated at its top value and the pulses hold. The transitions are as follows. WAIT→RUN happens on a line start. RUN→RUN happens on a line start, which restarts the line. RUN→END happens when the next count equals the top value. END→RUN happens on a line start.

Top module: `lcb_pulse_gen`

## Requirements
- R1: After reset and before the first line start, clpob_n = 1, pblk_n = 1, hblk = 0 and h_out equals h_in.
- R2: On the clock edge where hd is high, the counter becomes 0. Each pulse becomes its start level, XOR-ed once for every enabled toggle that equals 0. The clamp start level is control bit 0, the pre-blank start level is control bit 1, and blanking always starts at 0.
- R3: While the counter shows pixel p, each pulse equals its start level XOR the parity of the number of enabled toggles ≤ p. The output changes on the same edge at which the counter reaches the toggle value.
- R4: The register set in use is the one named by seq_idx at line start. Changes to seq_idx or line_odd during a line have no effect until the next line start.
- R5: The blanking alternation field sits in control bits [4:3]. A value of 0 applies all six blanking toggles on every line. A value of 1 applies toggles 1–2 on odd lines (line_odd = 1) and toggles 3–6 on even lines. Values 2 and 3 do the reverse.
- R6: While hblk = 1, h_out (bit 0 = H1) is 4'b1010 when the mask bit (control bit 2) of the line's set is 1, and 4'b0101 when it is 0. Otherwise h_out = h_in.
- R7: The counter stops at 2^CNT_W − 1. From then on the pulses hold their level until the next line start, so toggles past the line length have no effect.
- R8: wr_addr is {set, field}, with field in the low 4 bits. The field codes are: 0–1 clamp toggles 1–2, 2–3 pre-blank toggles 1–2, 4–9 blanking toggles 1–6, and 10 control. Set indices ≥ NSETS read as all zero, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| hd | input | 1 | Line-start strobe |
| seq_idx | input | $clog2(NSETS) | Vertical sequence index that selects the register set |
| line_odd | input | 1 | Line parity, 1 = odd |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(NSETS)+4 | Write address {set, field} |
| wr_data | input | CNT_W | Write data |
| h_in | input | 4 | Unmasked horizontal clocks, bit 0 = H1 |
| clpob_n | output | 1 | Optical-black clamp pulse, active low |
| pblk_n | output | 1 | Pre-blank pulse, active low |
| hblk | output | 1 | Horizontal blanking, active high |
| h_out | output | 4 | Horizontal clocks after masking |

## Verification
The bench builds the block with CNT_W = 6 and the default ten sets. The narrower counter makes saturation at pixel 63 reachable in a few dozen cycles, so every toggle position 0–63 can be swept one by one, with lines long enough to pass the top count and reach the END state. All ten sets are also exercised on both line parities with all four alternation values. Further runs scramble the index and parity in the middle of a line, issue line starts before saturation, and select a set index above the bank.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
    localparam int NFIELD  = 11;
    localparam int NHTOG   = 6;
    localparam int FLD_CT1 = 0;
    localparam int FLD_PT1 = 2;
    localparam int FLD_HT1 = 4;
    localparam int FLD_CTL = 10;
    localparam int CB_CLP  = 0;
    localparam int CB_PBL  = 1;
    localparam int CB_MASK = 2;
    localparam int CB_ALT  = 3;

    typedef enum logic [1:0] {
        LS_WAIT = 2'd0,
        LS_RUN  = 2'd1,
        LS_END  = 2'd2
    } line_state_t;
endpackage

// File: rtl/lcb_regbank.sv
module lcb_regbank
    import lcb_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int NSETS = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [$clog2(NSETS)+3:0]            wr_addr,
    input  logic [CNT_W-1:0]                    wr_data,
    input  logic [$clog2(NSETS)-1:0]            rd_sel,
    output logic [NFIELD-1:0][CNT_W-1:0]        rd_fld
);
    localparam int SEL_W = $clog2(NSETS);

    logic [NFIELD-1:0][CNT_W-1:0] mem [NSETS];
    logic [SEL_W-1:0] wset;
    logic [3:0]       wfld;

    assign wset = wr_addr[SEL_W+3:4];
    assign wfld = wr_addr[3:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                mem[s] <= '0;
            end
        end else if (wr_en && (int'(wset) < NSETS) && (int'(wfld) < NFIELD)) begin
            mem[wset][wfld] <= wr_data;
        end
    end

    always_comb begin
        if (int'(rd_sel) < NSETS) begin
            rd_fld = mem[rd_sel];
        end else begin
            rd_fld = '0;
        end
    end
endmodule

// File: rtl/lcb_toggle_unit.sv
module lcb_toggle_unit #(
    parameter int   N       = 2,
    parameter int   CNT_W   = 12,
    parameter logic RST_VAL = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      advance,
    input  logic                      start_val,
    input  logic [CNT_W-1:0]          cnt_next,
    input  logic [N-1:0][CNT_W-1:0]   tog,
    input  logic [N-1:0]              en,
    output logic                      q
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = en[i] && (tog[i] == cnt_next);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (restart) begin
            q <= start_val ^ (^hit);
        end else if (advance) begin
            q <= q ^ (^hit);
        end
    end

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !advance) |=> $stable(q));
endmodule

// File: rtl/lcb_pulse_gen.sv
module lcb_pulse_gen
    import lcb_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int NSETS = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hd,
    input  logic [$clog2(NSETS)-1:0]    seq_idx,
    input  logic                        line_odd,
    input  logic                        wr_en,
    input  logic [$clog2(NSETS)+3:0]    wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    input  logic [3:0]                  h_in,
    output logic                        clpob_n,
    output logic                        pblk_n,
    output logic                        hblk,
    output logic [3:0]                  h_out
);
    localparam int SEL_W = $clog2(NSETS);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    line_state_t state, state_n;
    logic [CNT_W-1:0] cnt, cnt_inc, cnt_next;
    logic [SEL_W-1:0] seq_q, sel;
    logic             odd_q, odd_sel, mask_q;
    logic             restart, advance;
    logic [NFIELD-1:0][CNT_W-1:0] rd;
    logic [CNT_W-1:0] ctrl;
    logic [1:0]       alt;
    logic [NHTOG-1:0] hen;
    logic [1:0]       afe_q;

    assign sel      = hd ? seq_idx  : seq_q;
    assign odd_sel  = hd ? line_odd : odd_q;
    assign cnt_inc  = cnt + ONE;
    assign restart  = hd;
    assign advance  = (state == LS_RUN) && !hd;
    assign cnt_next = hd ? '0 : (advance ? cnt_inc : cnt);
    assign ctrl     = rd[FLD_CTL];
    assign alt      = ctrl[CB_ALT+1:CB_ALT];

    lcb_regbank #(.CNT_W(CNT_W), .NSETS(NSETS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_sel(sel), .rd_fld(rd)
    );

    // line state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LS_WAIT;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            LS_WAIT: if (hd) state_n = LS_RUN;
            LS_RUN: begin
                if (hd)                  state_n = LS_RUN;
                else if (cnt_inc == MAXV) state_n = LS_END;
            end
            LS_END:  if (hd) state_n = LS_RUN;
            default: state_n = LS_WAIT;
        endcase
    end

    // counter and per-line captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            seq_q  <= '0;
            odd_q  <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            cnt <= cnt_next;
            if (hd) begin
                seq_q  <= seq_idx;
                odd_q  <= line_odd;
                mask_q <= ctrl[CB_MASK];
            end
        end
    end

    always_comb begin
        unique case (alt)
            2'd0:    hen = '1;
            2'd1:    hen = odd_sel ? 6'b000011 : 6'b111100;
            default: hen = odd_sel ? 6'b111100 : 6'b000011;
        endcase
    end

    for (genvar g = 0; g < 2; g++) begin : g_afe
        lcb_toggle_unit #(.N(2), .CNT_W(CNT_W), .RST_VAL(1'b1)) u_tog (
            .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
            .start_val(ctrl[g]), .cnt_next(cnt_next),
            .tog(rd[2*g+1:2*g]), .en(2'b11), .q(afe_q[g])
        );
    end

    lcb_toggle_unit #(.N(NHTOG), .CNT_W(CNT_W), .RST_VAL(1'b0)) u_hblk (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
        .start_val(1'b0), .cnt_next(cnt_next),
        .tog(rd[FLD_HT1+NHTOG-1:FLD_HT1]), .en(hen), .q(hblk)
    );

    assign clpob_n = afe_q[CB_CLP];
    assign pblk_n  = afe_q[CB_PBL];
    assign h_out   = hblk ? (mask_q ? 4'b1010 : 4'b0101) : h_in;

    // R2
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hd |=> (cnt == '0) && (state == LS_RUN));
    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_END && !hd) |=> (cnt == MAXV) && $stable(clpob_n) && $stable(pblk_n) && $stable(hblk));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_WAIT) |-> (clpob_n && pblk_n && !hblk));
    // R6
    mask_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hblk |-> (h_out == 4'b1010 || h_out == 4'b0101));
    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hd |=> $stable(seq_q) && $stable(odd_q) && $stable(mask_q));
endmodule

// File: tb/tb_lcb_pulse_gen.sv
module tb_lcb_pulse_gen;
    localparam int CW = 6;
    localparam int NS = 10;
    localparam int SW = $clog2(NS);
    localparam int AW = SW + 4;
    localparam int MAXP = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hd = 1'b0;
    logic [SW-1:0] seq_idx = '0;
    logic line_odd = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [3:0] h_in = 4'b0110;
    logic clpob_n, pblk_n, hblk;
    logic [3:0] h_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cfg [16][11];

    always #10 clk = ~clk;

    lcb_pulse_gen #(.CNT_W(CW), .NSETS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .hd(hd), .seq_idx(seq_idx), .line_odd(line_odd),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .h_in(h_in),
        .clpob_n(clpob_n), .pblk_n(pblk_n), .hblk(hblk), .h_out(h_out)
    );

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, nm, act, exp);
        end
    endtask

    task automatic wr(input int s, input int f, input int v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = AW'(s * 16 + f);
        wr_data = CW'(v);
        @(negedge clk);
        wr_en = 1'b0;
        if (s < NS && f < 11) cfg[s][f] = v & MAXP;
    endtask

    function automatic int exp_pulse(input int s, input int which, input int odd, input int p);
        int ctrl, alt, v, pe;
        bit en, first;
        pe = (p > MAXP) ? MAXP : p;
        ctrl = cfg[s][10];
        alt = (ctrl >> 3) & 3;
        if (which == 0) begin
            v = ctrl & 1;
            for (int i = 0; i < 2; i++) if (cfg[s][i] <= pe) v ^= 1;
        end else if (which == 1) begin
            v = (ctrl >> 1) & 1;
            for (int i = 2; i < 4; i++) if (cfg[s][i] <= pe) v ^= 1;
        end else begin
            v = 0;
            for (int i = 0; i < 6; i++) begin
                first = (i < 2);
                if (alt == 0)      en = 1;
                else if (alt == 1) en = odd ? first : !first;
                else               en = odd ? !first : first;
                if (en && cfg[s][4+i] <= pe) v ^= 1;
            end
        end
        return v;
    endfunction

    // mode 0: normal tags, 1: R4 scramble, 2: R8 tag
    task automatic run_line(input int s, input int odd, input int len, input int mode);
        int hb, mk, eh;
        string tg;
        @(negedge clk);
        hd = 1'b1;
        seq_idx = SW'(s);
        line_odd = odd[0];
        @(negedge clk);
        hd = 1'b0;
        mk = (cfg[s][10] >> 2) & 1;
        for (int p = 0; p < len; p++) begin
            if (mode == 1) begin
                seq_idx = SW'((p * 3 + 1) % NS);
                line_odd = ~line_odd;
            end
            h_in = 4'(p * 5 + 3);
            #1;
            if (mode == 1)      tg = "R4";
            else if (mode == 2) tg = "R8";
            else if (p == 0)    tg = "R2";
            else if (p >= MAXP) tg = "R7";
            else                tg = "R3";
            chk(tg, "clpob_n", int'(clpob_n), exp_pulse(s, 0, odd, p));
            chk(tg, "pblk_n", int'(pblk_n), exp_pulse(s, 1, odd, p));
            hb = exp_pulse(s, 2, odd, p);
            chk((mode == 0) ? "R5" : tg, "hblk", int'(hblk), hb);
            eh = hb ? (mk ? 4'b1010 : 4'b0101) : int'(h_in);
            chk((mode == 0) ? "R6" : tg, "h_out", int'(h_out), eh);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 16; s++)
            for (int f = 0; f < 11; f++) cfg[s][f] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        h_in = 4'b0110;
        #1;
        // R1 idle state before any line start
        chk("R1", "clpob_n", int'(clpob_n), 1);
        chk("R1", "pblk_n", int'(pblk_n), 1);
        chk("R1", "hblk", int'(hblk), 0);
        chk("R1", "h_out", int'(h_out), 4'b0110);

        // program all sets through the R8 address map
        for (int s = 0; s < NS; s++) begin
            for (int f = 0; f < 10; f++) wr(s, f, (s * 11 + f * 13 + 3) % (MAXP + 1));
            wr(s, 10, (s & 1) | (((s >> 1) & 1) << 1) | (((s >> 2) & 1) << 2) | ((s % 4) << 3));
        end
        wr(3, 0, 0);
        wr(5, 5, cfg[5][4]);

        // every set, both parities, long and short lines
        for (int s = 0; s < NS; s++) begin
            run_line(s, 1, MAXP + 6, 0);
            run_line(s, 0, 25, 0);
            run_line(s, 0, MAXP + 3, 0);
        end

        // R4: index and parity scrambled mid-line
        run_line(2, 1, 40, 1);
        run_line(7, 0, 40, 1);

        // R8: out-of-range set ignores writes, reads zero
        wr(12, 0, 9);
        wr(12, 10, 5);
        run_line(12, 1, 30, 2);

        // exhaustive single-position sweep on set 0
        wr(0, 10, 2 | (1 << 3));
        for (int t = 0; t <= MAXP; t++) begin
            wr(0, 0, t);
            wr(0, 1, MAXP);
            wr(0, 2, MAXP - t);
            wr(0, 4, t);
            wr(0, 5, (t + 7) % (MAXP + 1));
            run_line(0, t & 1, MAXP + 3, 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule